// File: doc/BRIEF.md
# Folded Single-Port Word Memory

This block is a synchronous single-port memory that software and logic see as 2048 words of 16 bits, while the storage is organised as 256 physical rows of 128 bits each. Eight logical words share every physical row. The upper eight address bits choose a row through a staged row decoder. That decoder builds two 4-to-16 one-hot predecode groups and ANDs them into 256 wordlines. The lower three address bits drive sixteen 8-to-1 column multiplexers, which pick one 16-bit word out of the selected row.

A user presents an address, a write enable and write data on one clock edge. The read data register holds the addressed word from the following cycle onward. A write changes only the sixteen physical columns that belong to the addressed word. The other word slots in the same row keep their contents. A write also shows its new data on the read port in the cycle after it, so a read of a just-written location returns the fresh value.

Top module: `fsr_array`

## Requirements
- R1: Each of the 2048 addresses stores its own 16-bit value; a later read of an address returns the value most recently written there.
- R2: Address bits [10:3] form the row index, and exactly one of the 256 wordlines is active for every access, namely the one equal to that index.
- R3: Address bits [2:0] form the column select; output bit j comes from physical column j*8 + column select of the selected row, so the eight words of one row are stored interleaved and independent.
- R4: A write alters only the 16 columns picked by the column select; the other 112 bits of the addressed row, and all other rows, keep their values.
- R5: Reads are synchronous: rdata shows the word addressed at a rising edge from just after that edge; when we is 1 at that edge, rdata shows the new wdata (write-first).
- R6: While we stays 0 and the address is unchanged, rdata holds its value.
- R7: While rst_n is 0, rdata reads 0 on the next edge; reset leaves stored words untouched.
- R8: Back-to-back writes to one row with different column selects all persist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| addr | input | 11 | Word address: [10:3] row, [2:0] column select |
| we | input | 1 | Write enable, 1 writes wdata to addr |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
The assertions assume a clean reset before any meaningful access. They also assume that addr, we and wdata are settled at every rising edge, since the write-first and hold properties compare values one and two cycles apart. The bench keeps to this by changing inputs only on falling edges and by releasing reset several cycles before traffic starts. It also repeats addresses with we low, so that the hold and read-after-write properties are triggered. All 2048 addresses, every column select in the first and last rows, and a reset in the middle of traffic are driven.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   // Physical column that carries output bit j for a given column select.
   function automatic int unsigned phys_col(input int unsigned bit_j,
                                            input int unsigned col_sel,
                                            input int unsigned fold);
      return bit_j * fold + col_sel;
   endfunction
endpackage

// File: rtl/fsr_predecode.sv
module fsr_predecode #(
   parameter int IN_W = 4
) (
   input  logic [IN_W-1:0]     sel,
   output logic [2**IN_W-1:0]  hot
);
   localparam int OUT_N = 2**IN_W;

   if (IN_W < 1 || IN_W > 4) begin : g_bad_width
      $error("fsr_predecode: IN_W must be 1..4");
   end

   for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign hot[i] = (sel == IN_W'(i));
   end
endmodule

// File: rtl/fsr_row_decoder.sv
module fsr_row_decoder #(
   parameter int ROW_BITS = 8,
   parameter int PRE_BITS = 4
) (
   input  logic [ROW_BITS-1:0]     row_idx,
   output logic [2**ROW_BITS-1:0]  wl
);
   localparam int ROWS  = 2**ROW_BITS;
   localparam int NGRP  = ROW_BITS / PRE_BITS;
   localparam int PRE_N = 2**PRE_BITS;

   if (ROW_BITS % PRE_BITS != 0) begin : g_bad_split
      $error("fsr_row_decoder: ROW_BITS must be a multiple of PRE_BITS");
   end

   logic [NGRP-1:0][PRE_N-1:0] grp_hot;

   for (genvar g = 0; g < NGRP; g++) begin : g_pre
      fsr_predecode #(.IN_W(PRE_BITS)) u_pre (
         .sel (row_idx[g*PRE_BITS +: PRE_BITS]),
         .hot (grp_hot[g])
      );
   end

   if (NGRP == 1) begin : g_flat
      assign wl = grp_hot[0];
   end else begin : g_staged
      logic [ROWS-1:0][NGRP-1:0] term;
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         for (genvar g = 0; g < NGRP; g++) begin : g_term
            localparam int SLOT = (r >> (g*PRE_BITS)) % PRE_N;
            assign term[r][g] = grp_hot[g][SLOT];
         end
         assign wl[r] = &term[r];
      end
   end
endmodule

// File: rtl/fsr_col_path.sv
module fsr_col_path #(
   parameter int WORD_W   = 16,
   parameter int COL_BITS = 3
) (
   input  logic [WORD_W*(2**COL_BITS)-1:0] row_rd,
   input  logic [COL_BITS-1:0]             col_sel,
   input  logic [WORD_W-1:0]               wdata,
   output logic [WORD_W-1:0]               word_rd,
   output logic [WORD_W*(2**COL_BITS)-1:0] wr_mask,
   output logic [WORD_W*(2**COL_BITS)-1:0] wr_bits
);
   import fsr_pkg::*;
   localparam int FOLD = 2**COL_BITS;

   if (COL_BITS < 1) begin : g_bad_cols
      $error("fsr_col_path: COL_BITS must be at least 1");
   end

   for (genvar j = 0; j < WORD_W; j++) begin : g_bit
      logic [FOLD-1:0] grp;
      for (genvar c = 0; c < FOLD; c++) begin : g_col
         localparam int PC = int'(phys_col(j, c, FOLD));
         assign grp[c]      = row_rd[PC];
         assign wr_mask[PC] = (col_sel == COL_BITS'(c));
         assign wr_bits[PC] = wdata[j];
      end
      assign word_rd[j] = grp[col_sel];
   end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
   parameter int WORD_W   = 16,
   parameter int ROW_BITS = 8,
   parameter int COL_BITS = 3,
   parameter int PRE_BITS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ROW_BITS+COL_BITS-1:0]  addr,
   input  logic                          we,
   input  logic [WORD_W-1:0]             wdata,
   output logic [WORD_W-1:0]             rdata
);
   localparam int ROWS  = 2**ROW_BITS;
   localparam int FOLD  = 2**COL_BITS;
   localparam int ROW_W = WORD_W * FOLD;

   if (WORD_W < 1) begin : g_bad_word
      $error("fsr_array: WORD_W must be positive");
   end

   logic [ROW_BITS-1:0] row_idx;
   logic [COL_BITS-1:0] col_sel;
   logic [ROWS-1:0]     wl;
   logic [ROW_W-1:0]    row_rd;
   logic [ROW_W-1:0]    wr_mask;
   logic [ROW_W-1:0]    wr_bits;
   logic [WORD_W-1:0]   word_rd;
   logic [ROW_W-1:0]    mem_q [ROWS];
   logic [WORD_W-1:0]   rdata_q;
   logic [1:0]          age_q;

   assign row_idx = addr[ROW_BITS+COL_BITS-1:COL_BITS];
   assign col_sel = addr[COL_BITS-1:0];

   fsr_row_decoder #(.ROW_BITS(ROW_BITS), .PRE_BITS(PRE_BITS)) u_rowdec (
      .row_idx (row_idx),
      .wl      (wl)
   );

   // Wordline-gated row read (one-hot OR across rows).
   always_comb begin
      row_rd = '0;
      for (int r = 0; r < ROWS; r++) begin
         row_rd = row_rd | ({ROW_W{wl[r]}} & mem_q[r]);
      end
   end

   fsr_col_path #(.WORD_W(WORD_W), .COL_BITS(COL_BITS)) u_colpath (
      .row_rd  (row_rd),
      .col_sel (col_sel),
      .wdata   (wdata),
      .word_rd (word_rd),
      .wr_mask (wr_mask),
      .wr_bits (wr_bits)
   );

   // Masked row write: only columns of the selected word change.
   always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS; r++) begin
         if (we && wl[r]) begin
            mem_q[r] <= (mem_q[r] & ~wr_mask) | (wr_bits & wr_mask);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         age_q   <= '0;
      end else begin
         rdata_q <= we ? wdata : word_rd;
         if (age_q != 2'd3) age_q <= age_q + 2'd1;
      end
   end

   assign rdata = rdata_q;

   // Decoder drives exactly the wordline named by the row index.
   assert_one_wordline_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(wl) && wl[row_idx]);

   // Untouched columns of the written row survive the write.
   assert_keep_columns_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((mem_q[$past(row_idx)] & ~$past(wr_mask)) ==
              ($past(row_rd) & ~$past(wr_mask))));

   // Write, then read the same address: stored word comes back.
   assert_read_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && $past(we) && !we && addr == $past(addr))
      |=> rdata == $past(wdata, 2));

   // Idle repeated address keeps read data steady.
   assert_hold_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && !$past(we) && !we && addr == $past(addr))
      |=> $stable(rdata));
endmodule

// File: tb/fsr_array_tb.sv
module fsr_array_tb_top;
   localparam int WORD_W = 16;
   localparam int AW     = 11;
   localparam int NWORDS = 2**AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AW-1:0]     addr_i = '0;
   logic              we_i = 1'b0;
   logic [WORD_W-1:0] wdata_i = '0;
   logic [WORD_W-1:0] rdata_o;
   logic [WORD_W-1:0] ref_q [NWORDS];
   logic [WORD_W-1:0] got;
   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fsr_array dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr_i),
      .we    (we_i),
      .wdata (wdata_i),
      .rdata (rdata_o)
   );

   function automatic logic [WORD_W-1:0] pat(input int a, input int salt);
      int v;
      v = a * 40503 + salt * 7919 + 23130;
      return v[WORD_W-1:0] ^ WORD_W'(a >> 3);
   endfunction

   task automatic check(input logic [WORD_W-1:0] act,
                        input logic [WORD_W-1:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input int a, input logic w, input logic [WORD_W-1:0] d);
      @(negedge clk);
      addr_i  = AW'(a);
      we_i    = w;
      wdata_i = d;
      @(posedge clk);
      #1;
      got = rdata_o;
      if (w) ref_q[a] = d;
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [WORD_W-1:0] prev;
      // R7: reset clears read register
      repeat (3) @(posedge clk);
      #1;
      check(rdata_o, '0, "R7 reset value");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R1/R5: fill every address, write-first echo
      for (int a = 0; a < NWORDS; a++) begin
         access(a, 1'b1, pat(a, 1));
         check(got, ref_q[a], "R5 write-first");
      end
      // R1/R2/R3: read back every address
      for (int a = 0; a < NWORDS; a++) begin
         access(a, 1'b0, '0);
         check(got, ref_q[a], "R1 R2 R3 readback");
      end

      // R8/R3: back-to-back writes, first and last rows, all column selects
      for (int rsel = 0; rsel < 2; rsel++) begin
         int row = (rsel == 0) ? 0 : 255;
         for (int c = 0; c < 8; c++) access(row*8 + c, 1'b1, pat(row*8 + c, 9 + c));
         for (int c = 0; c < 8; c++) begin
            access(row*8 + c, 1'b0, '0);
            check(got, ref_q[row*8 + c], "R8 R3 shared row");
         end
      end

      // R4: one column write leaves the row's other words alone
      access(100*8 + 5, 1'b1, 16'hFFFF);
      access(100*8 + 5, 1'b0, '0);
      check(got, 16'hFFFF, "R4 written word");
      for (int c = 0; c < 8; c++) begin
         if (c != 5) begin
            access(100*8 + c, 1'b0, '0);
            check(got, ref_q[100*8 + c], "R4 neighbour word");
         end
      end
      access(101*8 + 5, 1'b0, '0);
      check(got, ref_q[101*8 + 5], "R4 next row");

      // R6: held address, no write
      access(1234, 1'b0, '0);
      prev = got;
      for (int k = 0; k < 3; k++) begin
         access(1234, 1'b0, 16'h1111);
         check(got, prev, "R6 hold");
      end

      // R7: reset mid-run clears output but keeps contents
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check(rdata_o, '0, "R7 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      access(77, 1'b0, '0);
      check(got, ref_q[77], "R7 contents kept");
      access(2047, 1'b0, '0);
      check(got, ref_q[2047], "R7 R1 last address");

      @(negedge clk);
      we_i = 1'b0;
      finish_run();
   end
endmodule